// File: doc/BRIEF.md
# Dual-Rail Self-Timed Pipeline Stage

This block is one storage stage of a clockless point-to-point link. It is built only from ordinary edge-triggered flip-flops and gates. Each logical bit travels on two wires, a value rail and a parity rail. The phase of a bit is the XOR of its two rails. A new token flips the phase of every bit by toggling exactly one rail per bit. Signalling is transition-based and never returns to zero.

The stage holds one phase bit and compares three things: the phase of the arriving word, the phase it has stored, and the acknowledgement phase returned by the next stage. When every arriving bit differs from the stored phase and the next stage reports the stored phase, the stage raises its own capture clock. On that edge its flip-flops take both rails of every bit, together with an acknowledgement flop loaded from the arriving phase. The new stored phase then removes the firing condition, so the clock falls again. Stages are chained only at network nodes. The previous stage reads `up_ack`, and the next stage drives `dn_ack`.

Top module: `dr_stage`

## Requirements
- R1: While `rst_n` is low, every output rail (`dn_val`, `dn_par`) is 0 and `up_ack` is 0, so the stored phase is 0.
- R2: Bit i carries phase `val[i] ^ par[i]`. A token with data d and phase p is sent as `val = d`, `par = d ^ {W{p}}`. The stored word on the outputs always has the same phase in every bit.
- R3: A word in which only some bits have flipped phase relative to the stored phase is not captured. The outputs and `up_ack` stay unchanged until the last bit flips.
- R4: The stage captures only when `dn_ack` equals the stored phase. A complete new word that arrives while the next stage has not acknowledged leaves `dn_val`, `dn_par` and `up_ack` unchanged until `dn_ack` catches up.
- R5: On capture, `dn_val` and `dn_par` take exactly the arriving rails. The output data (`dn_val`) equals the sent data, and the output phase toggles.
- R6: `up_ack` changes on the same local edge that captures the word, and it then equals the phase of the captured word.
- R7: When the previous and next stages run with arbitrary delays, every word is delivered in order, exactly once, and unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset; clears all rails and the stored phase |
| up_val | input | W | Value rails of the word arriving from the previous stage |
| up_par | input | W | Parity rails of the word arriving from the previous stage |
| up_ack | output | 1 | Stored phase, returned to the previous stage as its acknowledgement |
| dn_val | output | W | Value rails of the stored word, driven to the next stage |
| dn_par | output | W | Parity rails of the stored word, driven to the next stage |
| dn_ack | input | 1 | Phase acknowledgement returned by the next stage |

## Verification
A rail flop that captures the wrong rail breaks the uniform phase of the output word. The next stage then never sees a complete token, and the stream stalls at once with a word missing. A stored phase that falls out of step with `up_ack` makes the previous stage send early or hold back. At the next transfer this shows as a word that is overwritten, duplicated or never accepted, so the scoreboard sees an out-of-order or surplus item. Early firing on a partial word or without acknowledgement is visible in the same step as a changed `dn_val` while the bench is holding the other side still.

// File: rtl/dr_link_pkg.sv
package dr_link_pkg;
  localparam int unsigned DR_WIDTH_DEFAULT = 8;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } dr_phase_e;

  localparam dr_phase_e DR_RESET_PHASE = PH_EVEN;
endpackage

// File: rtl/dr_phase_extract.sv
module dr_phase_extract #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] rail_val,
  input  logic [W-1:0] rail_par,
  output logic [W-1:0] phase
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign phase[i] = rail_val[i] ^ rail_par[i];
  end
endmodule

// File: rtl/dr_fire_gen.sv
module dr_fire_gen #(
  parameter int unsigned W = 8
) (
  input  logic         rst_n,
  input  logic [W-1:0] arrive_ph,
  input  logic         held_ph,
  input  logic         peer_ph,
  output logic         fire_clk
);
  logic [W-1:0] bit_flipped;
  logic         word_done;
  logic         peer_caught_up;

  for (genvar i = 0; i < W; i++) begin : g_cmp
    assign bit_flipped[i] = arrive_ph[i] ^ held_ph;
  end

  always_comb begin
    word_done      = &bit_flipped;
    peer_caught_up = (peer_ph == held_ph);
    fire_clk       = rst_n & word_done & peer_caught_up;
  end
endmodule

// File: rtl/dr_rail_bank.sv
module dr_rail_bank
  import dr_link_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         fire_clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_val,
  input  logic [W-1:0] d_par,
  input  logic         d_phase,
  output logic [W-1:0] q_val,
  output logic [W-1:0] q_par,
  output logic         q_phase
);
  logic [W-1:0] nxt_val;
  logic [W-1:0] nxt_par;
  logic         nxt_phase;

  always_comb begin
    nxt_val   = d_val;
    nxt_par   = d_par;
    nxt_phase = d_phase;
  end

  for (genvar i = 0; i < W; i++) begin : g_rail
    always_ff @(posedge fire_clk or negedge rst_n) begin
      if (!rst_n) q_val[i] <= 1'b0;
      else        q_val[i] <= nxt_val[i];
    end

    always_ff @(posedge fire_clk or negedge rst_n) begin
      if (!rst_n) q_par[i] <= DR_RESET_PHASE;
      else        q_par[i] <= nxt_par[i];
    end
  end

  always_ff @(posedge fire_clk or negedge rst_n) begin
    if (!rst_n) q_phase <= DR_RESET_PHASE;
    else        q_phase <= nxt_phase;
  end
endmodule

// File: rtl/dr_stage.sv
module dr_stage
  import dr_link_pkg::*;
#(
  parameter int unsigned W = DR_WIDTH_DEFAULT
) (
  input  logic         rst_n,
  input  logic [W-1:0] up_val,
  input  logic [W-1:0] up_par,
  output logic         up_ack,
  output logic [W-1:0] dn_val,
  output logic [W-1:0] dn_par,
  input  logic         dn_ack
);
  localparam int unsigned LEAD_BIT = W - 1;

  logic [W-1:0] arrive_ph;
  logic         held_ph;
  logic         fire_clk;

  dr_phase_extract #(.W(W)) u_extract (
    .rail_val (up_val),
    .rail_par (up_par),
    .phase    (arrive_ph)
  );

  dr_fire_gen #(.W(W)) u_fire (
    .rst_n     (rst_n),
    .arrive_ph (arrive_ph),
    .held_ph   (held_ph),
    .peer_ph   (dn_ack),
    .fire_clk  (fire_clk)
  );

  // The acknowledgement flop loads the arriving phase, which is known
  // before the edge, instead of decoding the stored rails after capture.
  dr_rail_bank #(.W(W)) u_bank (
    .fire_clk (fire_clk),
    .rst_n    (rst_n),
    .d_val    (up_val),
    .d_par    (up_par),
    .d_phase  (arrive_ph[LEAD_BIT]),
    .q_val    (dn_val),
    .q_par    (dn_par),
    .q_phase  (held_ph)
  );

  assign up_ack = held_ph;
endmodule

// File: rtl/dr_stage_chk.sv
module dr_stage_chk #(
  parameter int unsigned W = 8
) (
  input logic         rst_n,
  input logic         fire_clk,
  input logic [W-1:0] up_val,
  input logic [W-1:0] up_par,
  input logic         up_ack,
  input logic [W-1:0] dn_val,
  input logic [W-1:0] dn_par,
  input logic         dn_ack
);
  logic [W-1:0] in_ph;
  logic [W-1:0] out_ph;

  always_comb begin
    in_ph  = up_val ^ up_par;
    out_ph = dn_val ^ dn_par;
  end

  // The falling edge of the local clock comes once the capture has settled.
  always @(negedge fire_clk) begin
    if (rst_n) begin
      p_full_word_r3: assert (in_ph == {W{in_ph[0]}})
        else $error("partial word captured");
      p_peer_ready_r4: assert (out_ph[0] != dn_ack)
        else $error("capture without next-stage acknowledgement");
      p_rails_intact_r5: assert (dn_val == up_val && dn_par == up_par)
        else $error("captured rails differ from arriving rails");
      p_uniform_phase_r2: assert (out_ph == {W{out_ph[0]}})
        else $error("output word phase not uniform");
      p_ack_early_r6: assert (up_ack == out_ph[0])
        else $error("acknowledgement not equal to captured phase");
    end
  end
endmodule

bind dr_stage dr_stage_chk #(.W(W)) u_chk (
  .rst_n    (rst_n),
  .fire_clk (fire_clk),
  .up_val   (up_val),
  .up_par   (up_par),
  .up_ack   (up_ack),
  .dn_val   (dn_val),
  .dn_par   (dn_par),
  .dn_ack   (dn_ack)
);

// File: tb/dr_stage_bench.sv
module dr_stage_bench;
  localparam int W      = 8;
  localparam int NWORDS = 200;
  localparam logic [W-1:0] LO_MASK = {W{1'b1}} >> (W / 2);

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] up_val, up_par, dn_val, dn_par;
  logic         up_ack, dn_ack;

  int n_chk  = 0;
  int n_fail = 0;
  int n_rx   = 0;
  bit done   = 1'b0;
  logic         s_ph;
  logic         r_ph;
  logic [W-1:0] exp_q[$];

  always #5 clk = ~clk;

  dr_stage #(.W(W)) u_dr_stage (
    .rst_n (rst_n), .up_val (up_val), .up_par (up_par), .up_ack (up_ack),
    .dn_val (dn_val), .dn_par (dn_par), .dn_ack (dn_ack)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  function automatic logic [W-1:0] dn_phase();
    return dn_val ^ dn_par;
  endfunction

  // Driver: waits for the acknowledgement, then flips the phase of every bit.
  task automatic send_word(logic [W-1:0] d);
    while (up_ack !== s_ph) @(negedge clk);
    s_ph = ~s_ph;
    exp_q.push_back(d);
    up_val = d;
    up_par = d ^ {W{s_ph}};
  endtask

  // Monitor: acts as the next stage and consumes one token per call.
  task automatic take_word();
    logic [W-1:0] ph;
    logic [W-1:0] exp;
    forever begin
      ph = dn_phase();
      if (ph == {W{ph[0]}} && ph[0] != r_ph) break;
      @(negedge clk);
    end
    if (exp_q.size() == 0) begin
      chk("R7 surplus word", {24'd0, dn_val}, 32'hFFFF_FFFF);
    end else begin
      exp = exp_q.pop_front();
      chk("R7 order/data", {24'd0, dn_val}, {24'd0, exp});
    end
    n_rx++;
    repeat ($urandom_range(0, 3)) @(negedge clk);
    r_ph   = ~r_ph;
    dn_ack = r_ph;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hang expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    rst_n  = 1'b0;
    up_val = '0;
    up_par = '0;
    dn_ack = 1'b0;
    s_ph   = 1'b0;
    r_ph   = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dn_val", {24'd0, dn_val}, 32'd0);
    chk("R1 dn_par", {24'd0, dn_par}, 32'd0);
    chk("R1 up_ack", {31'd0, up_ack}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: only the low half of the word flips phase.
    d    = 8'hA5;
    s_ph = 1'b1;
    up_val = (d & LO_MASK) | (up_val & ~LO_MASK);
    up_par = ((d ^ {W{s_ph}}) & LO_MASK) | (up_par & ~LO_MASK);
    repeat (2) @(negedge clk);
    chk("R3 partial dn_val", {24'd0, dn_val}, 32'd0);
    chk("R3 partial up_ack", {31'd0, up_ack}, 32'd0);
    up_val = d;
    up_par = d ^ {W{s_ph}};
    @(negedge clk);
    chk("R5 dn_val", {24'd0, dn_val}, {24'd0, d});
    chk("R2 dn_par", {24'd0, dn_par}, {24'd0, d ^ {W{1'b1}}});
    chk("R6 up_ack", {31'd0, up_ack}, 32'd1);

    // R4: next stage has not acknowledged, so a new word must wait.
    s_ph   = 1'b0;
    up_val = 8'h3C;
    up_par = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R4 held dn_val", {24'd0, dn_val}, 32'h0000_00A5);
    chk("R4 held up_ack", {31'd0, up_ack}, 32'd1);
    dn_ack = 1'b1;
    @(negedge clk);
    chk("R4 released dn_val", {24'd0, dn_val}, 32'h0000_003C);
    chk("R2 released dn_par", {24'd0, dn_par}, 32'h0000_003C);
    chk("R6 released up_ack", {31'd0, up_ack}, 32'd0);
    dn_ack = 1'b0;
    r_ph   = 1'b0;
    @(negedge clk);

    // R7: random stream with random delays on both sides.
    fork
      begin
        for (int i = 0; i < NWORDS; i++) begin
          repeat ($urandom_range(0, 3)) @(negedge clk);
          send_word(W'($urandom));
        end
      end
      begin
        for (int k = 0; k < NWORDS; k++) take_word();
      end
    join
    repeat (4) @(negedge clk);
    chk("R7 received count", n_rx, NWORDS);
    chk("R7 nothing left", exp_q.size(), 0);
    chk("R7 no extra token", {31'd0, dn_phase() != {W{r_ph}}}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule